// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers up to 128 level-sensitive interrupt sources (96 by default) and presents them to one processor as a single interrupt request line. A 32-bit register bus lets the processor configure and query the controller. Sources are grouped into banks of 32. Each bank has a mask word that software changes only through two write strobes, one that masks bits and one that unmasks them. Each bank also has a read-only word showing raw requests that are not masked.

Every source has a level register, and its bits [7:2] give the source a priority, where 0 is the most urgent. A threshold register can shut out sources that are not urgent enough. The processor reads an active-number register to learn which source to service. That number stays latched, and the request line stays low, until the processor writes an acknowledge to the control register. A soft reset returns all configuration to its initial values. A status flag reports when that soft reset has finished.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset the masks are all 1 and the threshold reads 0xFF. The status register (0x014) bit 0 reads 1, the request line is low, and the revision register (0x000) reads 0x21 in its low byte (major version in [7:4], minor version in [3:0]).
- R2: A write to the unmask port of bank b (0x088 + 0x20*b) clears the mask bits written as 1. A write to the mask port (0x08C + 0x20*b) sets the mask bits written as 1. All other mask bits keep their value. The mask word reads back at 0x084 + 0x20*b.
- R3: The pending word of bank b (0x098 + 0x20*b) reads the bank's raw source levels AND NOT its mask.
- R4: The request line is high exactly when some unmasked, threshold-eligible source is asserted and no active number is latched.
- R5: A read of the active register (0x040) returns, in bits [6:0], the eligible source with the lowest priority value. Ties go to the lowest source index. The read returns 0 when no source is eligible, and bits [31:7] always read 0.
- R6: When the threshold (0x068, bits [7:0]) is not 0xFF, only sources whose priority value is strictly below the threshold are eligible.
- R7: Reading the active register while a source is eligible latches that number. Later reads return the latched number until a control write (0x048) with bit 0 = 1. A control write with bit 0 = 0 changes nothing.
- R8: Writing 1 to bit 1 of the system config register (0x010) starts a soft reset. The status bit 0 reads 0 on the next read and returns to 1 after RST_CYCLES cycles. Masks return to all 1, levels to 0, threshold to 0xFF, autoidle to 0, and any latched number is released.
- R9: System config bit 0 is the autoidle flag and reads back as written. Bit 1 always reads 0.
- R10: The level register of source n (0x100 + 4*n) keeps bits [7:2] and reads 0 in all other bits.
- R11: Bus writes issued while a soft reset is still in progress are ignored.
- R12: Data reads return the addressed register one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_src_i | input | NUM_SRC | Level-sensitive source requests, synchronous to clk_i |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge write and a change of the source levels can land in the same clock cycle. After such an acknowledge, the new choice must already include the source that rose in that cycle. The bench provokes this by raising a more urgent source on the same edge as the acknowledge. It then judges the outcome from the next active-register read and from the request line. The same question applies to an active-register read that coincides with a source change. Random sequences mix source changes, latching reads and acknowledges, and a bench model predicts every read value and the state of the request line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_W = 32;
    localparam int PRIO_W = 6;
    localparam int ADDR_W = 12;
    localparam int NUM_W  = 7;

    localparam logic [ADDR_W-1:0] A_REV     = 12'h000;
    localparam logic [ADDR_W-1:0] A_SYSCFG  = 12'h010;
    localparam logic [ADDR_W-1:0] A_SYSSTAT = 12'h014;
    localparam logic [ADDR_W-1:0] A_ACTIVE  = 12'h040;
    localparam logic [ADDR_W-1:0] A_CTRL    = 12'h048;
    localparam logic [ADDR_W-1:0] A_THRESH  = 12'h068;
    localparam logic [ADDR_W-1:0] A_BANK0   = 12'h080;
    localparam logic [ADDR_W-1:0] A_LEVEL0  = 12'h100;

    localparam logic [4:0] SUB_MASK  = 5'h04;
    localparam logic [4:0] SUB_UNMSK = 5'h08;
    localparam logic [4:0] SUB_MSK   = 5'h0C;
    localparam logic [4:0] SUB_PEND  = 5'h18;

    localparam logic [7:0] THRESH_OFF = 8'hFF;

    typedef struct packed {
        logic                wr;
        logic                rd;
        logic [ADDR_W-1:0]   addr;
        logic [BANK_W-1:0]   wdata;
    } bus_req_t;

    typedef struct packed {
        logic             any;
        logic [NUM_W-1:0] num;
    } pick_t;

    function automatic logic prio_eligible(input logic [PRIO_W-1:0] p,
                                           input logic [7:0] thr);
        return (thr == THRESH_OFF) || ({2'b00, p} < thr);
    endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank
    import irqc_pkg::*;
(
    input  logic              clk_i,
    input  logic              init_i,
    input  logic              unmask_stb_i,
    input  logic              mask_stb_i,
    input  logic [BANK_W-1:0] wdata_i,
    input  logic [BANK_W-1:0] src_i,
    output logic [BANK_W-1:0] mask_o,
    output logic [BANK_W-1:0] pend_o
);
    logic [BANK_W-1:0] mask_q;

    always_ff @(posedge clk_i) begin
        if (init_i) begin
            mask_q <= '1;
        end else if (unmask_stb_i) begin
            mask_q <= mask_q & ~wdata_i;
        end else if (mask_stb_i) begin
            mask_q <= mask_q | wdata_i;
        end
    end

    assign mask_o = mask_q;
    assign pend_o = src_i & ~mask_q;
endmodule

// File: rtl/irqc_level_file.sv
module irqc_level_file
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic                           clk_i,
    input  logic                           init_i,
    input  logic                           we_i,
    input  logic [NUM_W-1:0]               idx_i,
    input  logic [PRIO_W-1:0]              prio_i,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o
);
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

    always_ff @(posedge clk_i) begin
        if (init_i) begin
            prio_q <= '0;
        end else if (we_i) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (idx_i == NUM_W'(i)) prio_q[i] <= prio_i;
            end
        end
    end

    assign prio_o = prio_q;
endmodule

// File: rtl/irqc_prio_select.sv
module irqc_prio_select
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [7:0]                     thr_i,
    output pick_t                          pick_o
);
    always_comb begin
        logic [PRIO_W-1:0] best_p;
        pick_o = '0;
        best_p = '1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend_i[i] && prio_eligible(prio_i[i], thr_i)) begin
                if (!pick_o.any || (prio_i[i] < best_p)) begin
                    pick_o.any = 1'b1;
                    pick_o.num = NUM_W'(i);
                    best_p     = prio_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int         NUM_SRC    = 96,
    parameter int         RST_CYCLES = 4,
    parameter logic [3:0] REV_MAJOR  = 4'd2,
    parameter logic [3:0] REV_MINOR  = 4'd1
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bus_en_i,
    input  logic               bus_we_i,
    input  logic [11:0]        bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [NUM_SRC-1:0] irq_src_i,
    output logic               irq_o
);
    localparam int NB    = NUM_SRC / BANK_W;
    localparam int CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [ADDR_W-1:0] BANK_END  = ADDR_W'(128 + NB * 32);
    localparam logic [ADDR_W-1:0] LEVEL_END = ADDR_W'(256 + NUM_SRC * 4);

    bus_req_t          req;
    logic [CNT_W-1:0]  srst_cnt;
    logic              srst_done;
    logic              soft_init, hw_or_soft;
    logic              autoidle_q;
    logic [7:0]        thr_q;
    logic              held_q;
    logic [NUM_W-1:0]  act_q;
    logic              in_bank, in_level;
    logic [1:0]        bsel;
    logic [4:0]        bsub;
    logic [ADDR_W-1:0] lvl_off;
    logic [NUM_W-1:0]  lvl_idx;
    logic              ack;
    pick_t             pick;
    logic [31:0]       rd_val;

    logic [NB-1:0][BANK_W-1:0]      mask_w, pend_w;
    logic [NUM_SRC-1:0]             pend_flat;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;

    // writes are accepted only when no soft reset is running (R11)
    assign req.wr    = bus_en_i & bus_we_i & srst_done;
    assign req.rd    = bus_en_i & ~bus_we_i;
    assign req.addr  = bus_addr_i;
    assign req.wdata = bus_wdata_i;

    assign srst_done  = (srst_cnt == '0);
    assign soft_init  = req.wr && (req.addr == A_SYSCFG) && req.wdata[1];
    assign hw_or_soft = rst_i | soft_init;
    assign ack        = req.wr && (req.addr == A_CTRL) && req.wdata[0];

    assign in_bank  = (req.addr >= A_BANK0) && (req.addr < BANK_END);
    assign bsel     = req.addr[6:5];
    assign bsub     = req.addr[4:0];
    assign in_level = (req.addr >= A_LEVEL0) && (req.addr < LEVEL_END)
                      && (req.addr[1:0] == 2'b00);
    assign lvl_off  = req.addr - A_LEVEL0;
    assign lvl_idx  = NUM_W'(lvl_off >> 2);

    // soft reset sequencer
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            srst_cnt <= '0;
        end else if (soft_init) begin
            srst_cnt <= CNT_W'(RST_CYCLES);
        end else if (!srst_done) begin
            srst_cnt <= srst_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (hw_or_soft) begin
            autoidle_q <= 1'b0;
            thr_q      <= THRESH_OFF;
        end else if (req.wr) begin
            if (req.addr == A_SYSCFG) autoidle_q <= req.wdata[0];
            if (req.addr == A_THRESH) thr_q      <= req.wdata[7:0];
        end
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            logic unmask_stb, mask_stb;
            assign unmask_stb = req.wr && in_bank && (bsel == 2'(b)) && (bsub == SUB_UNMSK);
            assign mask_stb   = req.wr && in_bank && (bsel == 2'(b)) && (bsub == SUB_MSK);
            irqc_mask_bank u_bank (
                .clk_i       (clk_i),
                .init_i      (hw_or_soft),
                .unmask_stb_i(unmask_stb),
                .mask_stb_i  (mask_stb),
                .wdata_i     (req.wdata),
                .src_i       (irq_src_i[b*BANK_W +: BANK_W]),
                .mask_o      (mask_w[b]),
                .pend_o      (pend_w[b])
            );
            assign pend_flat[b*BANK_W +: BANK_W] = pend_w[b];
        end
    endgenerate

    irqc_level_file #(.NUM_SRC(NUM_SRC)) u_levels (
        .clk_i (clk_i),
        .init_i(hw_or_soft),
        .we_i  (req.wr && in_level),
        .idx_i (lvl_idx),
        .prio_i(req.wdata[7:2]),
        .prio_o(prio)
    );

    irqc_prio_select #(.NUM_SRC(NUM_SRC)) u_select (
        .pend_i(pend_flat),
        .prio_i(prio),
        .thr_i (thr_q),
        .pick_o(pick)
    );

    // active number latch
    always_ff @(posedge clk_i) begin
        if (hw_or_soft) begin
            held_q <= 1'b0;
            act_q  <= '0;
        end else if (ack) begin
            held_q <= 1'b0;
        end else if (req.rd && (req.addr == A_ACTIVE) && !held_q && pick.any) begin
            held_q <= 1'b1;
            act_q  <= pick.num;
        end
    end

    assign irq_o = pick.any & ~held_q;

    always_comb begin
        rd_val = '0;
        if (req.addr == A_REV) begin
            rd_val = {24'd0, REV_MAJOR, REV_MINOR};
        end else if (req.addr == A_SYSCFG) begin
            rd_val = {31'd0, autoidle_q};
        end else if (req.addr == A_SYSSTAT) begin
            rd_val = {31'd0, srst_done};
        end else if (req.addr == A_ACTIVE) begin
            rd_val = {25'd0, held_q ? act_q : pick.num};
        end else if (req.addr == A_THRESH) begin
            rd_val = {24'd0, thr_q};
        end else if (in_bank) begin
            for (int b = 0; b < NB; b++) begin
                if (bsel == 2'(b)) begin
                    if (bsub == SUB_MASK) rd_val = mask_w[b];
                    if (bsub == SUB_PEND) rd_val = pend_w[b];
                end
            end
        end else if (in_level) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (lvl_idx == NUM_W'(i)) rd_val = {24'd0, prio[i], 2'b00};
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bus_rdata_o <= '0;
        end else if (req.rd) begin
            bus_rdata_o <= rd_val;
        end
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic        clk_i,
    input logic        rst_i,
    input logic        bus_en_i,
    input logic        bus_we_i,
    input logic [11:0] bus_addr_i,
    input logic [31:0] bus_wdata_i,
    input logic [31:0] bus_rdata_o,
    input logic        irq_o,
    input logic        any_src,
    input logic        held,
    input logic [6:0]  act_num,
    input logic        srst_done
);
    logic ack_w, srst_w, sir_rd;
    assign ack_w  = bus_en_i && bus_we_i && (bus_addr_i == 12'h048) && bus_wdata_i[0] && srst_done;
    assign srst_w = bus_en_i && bus_we_i && (bus_addr_i == 12'h010) && bus_wdata_i[1] && srst_done;
    assign sir_rd = bus_en_i && !bus_we_i && (bus_addr_i == 12'h040);

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> any_src); // R4
    AST_ACTIVE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (held && !ack_w && !srst_w) |=> $stable(act_num)); // R7
    AST_ACK_RELEASES: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_w |=> !held); // R7
    AST_SRST_DONE_DROPS: assert property (@(posedge clk_i) disable iff (rst_i)
        srst_w |=> !srst_done); // R8
    AST_BUSY_NO_IRQ: assert property (@(posedge clk_i) disable iff (rst_i)
        !srst_done |-> !irq_o); // R11
    AST_ACTIVE_NARROW: assert property (@(posedge clk_i) disable iff (rst_i)
        sir_rd |=> (bus_rdata_o[31:7] == 25'd0)); // R5
endmodule

bind banked_irq_ctrl irqc_checker u_irqc_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .bus_en_i   (bus_en_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o),
    .any_src    (|irq_src_i),
    .held       (held_q),
    .act_num    (act_q),
    .srst_done  (srst_done)
);

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 96;
    localparam int NB = NS / 32;
    localparam int RSTC = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] src = '0;
    logic          irq;

    int n_checks = 0;
    int n_errors = 0;

    logic [NS-1:0] m_mask;
    logic [5:0]    m_prio [NS];
    logic [7:0]    m_thr;
    bit            m_held;
    logic [6:0]    m_act;

    banked_irq_ctrl #(.NUM_SRC(NS), .RST_CYCLES(RSTC)) i_banked_irq_ctrl (
        .clk_i(clk), .rst_i(rst), .bus_en_i(bus_en), .bus_we_i(bus_we),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_src_i(src), .irq_o(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    function automatic void model_reset();
        m_mask = '1;
        for (int i = 0; i < NS; i++) m_prio[i] = '0;
        m_thr  = 8'hFF;
        m_held = 1'b0;
        m_act  = '0;
    endfunction

    function automatic void model_pick(output bit any, output logic [6:0] num);
        logic [5:0] bp;
        any = 1'b0; num = '0; bp = '1;
        for (int i = 0; i < NS; i++) begin
            if (src[i] && !m_mask[i] && (m_thr == 8'hFF || {2'b00, m_prio[i]} < m_thr)) begin
                if (!any || m_prio[i] < bp) begin
                    any = 1'b1; num = 7'(i); bp = m_prio[i];
                end
            end
        end
    endfunction

    task automatic check_irq(input string req);
        bit any; logic [6:0] num;
        model_pick(any, num);
        check(irq === (any && !m_held), req, {31'd0, irq}, {31'd0, any && !m_held});
    endtask

    task automatic m_unmask(input int b, input logic [31:0] d);
        bus_write(12'(136 + 32 * b), d);
        m_mask[b*32 +: 32] = m_mask[b*32 +: 32] & ~d;
    endtask

    task automatic m_maskset(input int b, input logic [31:0] d);
        bus_write(12'(140 + 32 * b), d);
        m_mask[b*32 +: 32] = m_mask[b*32 +: 32] | d;
    endtask

    task automatic m_level(input int n, input logic [31:0] d);
        bus_write(12'(256 + 4 * n), d);
        m_prio[n] = d[7:2];
    endtask

    task automatic m_thresh(input logic [7:0] t);
        bus_write(12'h068, {24'd0, t});
        m_thr = t;
    endtask

    task automatic m_active_read(input string req);
        bit any; logic [6:0] num; logic [31:0] exp, d;
        model_pick(any, num);
        exp = {25'd0, m_held ? m_act : num};
        bus_read(12'h040, d);
        check(d === exp, req, d, exp);
        if (!m_held && any) begin m_held = 1'b1; m_act = num; end
    endtask

    task automatic m_ack(input logic [31:0] d);
        bus_write(12'h048, d);
        if (d[0]) m_held = 1'b0;
    endtask

    task automatic m_pend_read(input int b);
        logic [31:0] d, exp;
        exp = src[b*32 +: 32] & ~m_mask[b*32 +: 32];
        bus_read(12'(152 + 32 * b), d);
        check(d === exp, "R3 pending word", d, exp);
    endtask

    initial begin
        logic [31:0] d;
        int polls;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 32'd0);
        bus_read(12'h000, d);
        check(d[7:0] === 8'h21, "R1 revision", d, 32'h21);
        bus_read(12'h014, d);
        check(d === 32'd1, "R1 status done", d, 32'd1);
        bus_read(12'h068, d);
        check(d === 32'hFF, "R1 threshold", d, 32'hFF);
        for (int b = 0; b < NB; b++) begin
            bus_read(12'(132 + 32 * b), d);
            check(d === 32'hFFFF_FFFF, "R1 mask word", d, 32'hFFFF_FFFF);
        end
        bus_read(12'h040, d);
        check(d === 32'd0, "R5 active none", d, 32'd0);

        // R9 autoidle
        bus_write(12'h010, 32'h1);
        bus_read(12'h010, d);
        check(d === 32'h1, "R9 autoidle readback", d, 32'h1);

        // R10 level readback
        m_level(7, 32'hFFFF_FFFF);
        bus_read(12'(256 + 28), d);
        check(d === 32'hFC, "R10 level bits", d, 32'hFC);

        // R2 mask strobes
        m_unmask(1, 32'h0000_00F0);
        m_maskset(1, 32'h0000_0030);
        bus_read(12'h0A4, d);
        check(d === 32'hFFFF_FF3F, "R2 mask strobes", d, 32'hFFFF_FF3F);
        m_maskset(1, 32'hFFFF_FFFF);

        // R5 tie on priority goes to lower index
        m_level(5, 32'h0C);
        m_level(9, 32'h0C);
        m_level(7, 32'h0);
        m_unmask(0, 32'h0000_0220);
        @(negedge clk) src[5] = 1'b1; src[9] = 1'b1;
        @(negedge clk) check_irq("R4 irq with eligible");
        m_active_read("R5 tie lowest index");
        @(negedge clk) check_irq("R7 irq low while held");

        // R7 bit0=0 control write is no ack
        m_ack(32'h2);
        m_active_read("R7 still latched");
        // same-cycle: acknowledge as a more urgent source rises
        m_level(2, 32'h00);
        m_unmask(0, 32'h4);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h048; bus_wdata = 32'h1; src[2] = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        m_held = 1'b0;
        check_irq("R4 irq after ack");
        m_active_read("R7 new pick after ack");
        m_ack(32'h1);

        // R6 threshold
        src = '0;
        m_unmask(0, 32'hFFFF_FFFF);
        @(negedge clk) src[3] = 1'b1;
        m_level(3, 32'h0C);
        m_thresh(8'h03);
        @(negedge clk) check_irq("R6 prio equal threshold blocked");
        m_thresh(8'h04);
        @(negedge clk) check_irq("R6 prio below threshold passes");
        m_pend_read(0);

        // random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0: m_unmask(int'($urandom % NB), $urandom & $urandom);
                1: m_maskset(int'($urandom % NB), $urandom & $urandom);
                2: m_level(int'($urandom % NS), $urandom);
                3: m_thresh(($urandom % 3 == 0) ? 8'hFF : 8'($urandom % 72));
                4: begin
                    @(negedge clk);
                    for (int w = 0; w < NB; w++) src[w*32 +: 32] = $urandom & $urandom & $urandom;
                end
                5: m_active_read("R5 random active read");
                6: m_ack(($urandom % 4 == 0) ? 32'h0 : 32'h1);
                default: m_pend_read(int'($urandom % NB));
            endcase
            @(negedge clk) check_irq("R4 random irq");
        end

        // R8 / R11 soft reset
        bus_write(12'h010, 32'h3);
        bus_read(12'h014, d);
        check(d === 32'd0, "R8 status low after request", d, 32'd0);
        bus_write(12'h088, 32'hFFFF_FFFF);
        polls = 0;
        d = 32'd0;
        while (d[0] !== 1'b1 && polls < 20) begin
            bus_read(12'h014, d);
            polls++;
        end
        check(d === 32'd1 && polls <= RSTC, "R8 status returns", 32'(polls), 32'(RSTC));
        model_reset();
        bus_read(12'h084, d);
        check(d === 32'hFFFF_FFFF, "R11 write during reset ignored", d, 32'hFFFF_FFFF);
        bus_read(12'h068, d);
        check(d === 32'hFF, "R8 threshold restored", d, 32'hFF);
        bus_read(12'h010, d);
        check(d === 32'h0, "R8 autoidle cleared", d, 32'h0);
        bus_read(12'(256 + 12), d);
        check(d === 32'h0, "R8 level cleared", d, 32'h0);
        @(negedge clk) check_irq("R8 irq after soft reset");

        // R12 read latency
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 12'h068;
        @(negedge clk);
        bus_en = 1'b0;
        check(bus_rdata === 32'hFF, "R12 one cycle read", bus_rdata, 32'hFF);

        finish_run();
    end
endmodule